// File: doc/BRIEF.md
# Branch Target Address Generator

This block computes the 16-bit address that the fetch unit uses next when a jump is taken. It covers three ways of forming that address.

- **Relative:** a signed byte is added to the address that follows the jump instruction.
- **Absolute within a page:** eleven target bits are taken from the instruction. Three of them come from the top of the opcode and eight from the second byte. The upper five bits are kept from the address that follows the instruction.
- **Indexed:** an unsigned accumulator byte is added to a base. The base is either the following instruction address or a 16-bit data pointer.

The block also reports whether the target lies in the same 2K page as the following instruction.

The address arithmetic is combinational, and both results are captured in an output register. The caller presents the current instruction address, its length, both instruction bytes, the accumulator, the data pointer and a 2-bit mode, and then pulses `valid_i`. The registered target and the page flag appear after that clock edge. They hold until the next pulse.

Deciding whether a condition is met, pushing return addresses and fetching the instruction are all handled elsewhere.

Top module: `branch_target_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `target_o` becomes 0000h and `same_page_o` becomes 0.
- R2: When `valid_i` is low at a clock edge, `target_o` and `same_page_o` keep their values.
- R3: The follow-on address is `insn_addr_i + insn_len_i`, taken modulo 2^16. It is the base for relative and PC-indexed targets and for the page comparison.
- R4: Mode encoding on `mode_i`: 0 is relative, 1 is absolute-in-page, 2 is PC-indexed and 3 is pointer-indexed.
- R5: In relative mode the target is the follow-on address plus `operand_i` read as a two's-complement value from -128 to +127, taken modulo 2^16. For example, an instruction at 1000h of length 2 with offset 3Eh gives 1040h.
- R6: In absolute mode the target bits are filled as follows: bits 7..0 are `operand_i`, bits 10..8 are `opcode_i[7:5]`, and bits 15..11 are bits 15..11 of the follow-on address.
- R7: In PC-indexed mode the target is the follow-on address plus `acc_i`, read unsigned, taken modulo 2^16.
- R8: In pointer-indexed mode the target is `dptr_i` plus `acc_i`, read unsigned, taken modulo 2^16.
- R9: `same_page_o` is 1 exactly when bits 15..11 of the target equal bits 15..11 of the follow-on address. It is therefore always 1 in absolute mode.
- R10: The outputs reflect the inputs sampled at the clock edge where `valid_i` is high, and they are visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Capture strobe for the output register |
| mode_i | input | 2 | Target formation mode |
| insn_addr_i | input | 16 | Address of the jump instruction |
| insn_len_i | input | 2 | Length of the instruction in bytes |
| opcode_i | input | 8 | First instruction byte |
| operand_i | input | 8 | Second instruction byte |
| acc_i | input | 8 | Accumulator value |
| dptr_i | input | 16 | Data pointer value |
| target_o | output | 16 | Registered target address |
| same_page_o | output | 1 | Registered same-2K-page indication |

## Verification
Two effects can meet in one cycle. One is the increment to the follow-on address, which can carry across a 2K page boundary. The other is the target formation that takes its page or base from that increment.

The bench provokes this with an absolute jump at 07FEh of length 2. Its page bits must come from 0800h and not from 07FEh. Relative and indexed sums that wrap past FFFFh at the same time as the increment exercise the same meeting. In each case the registered target and page flag are compared against values worked out from the follow-on address alone.

// File: rtl/bta_pkg.sv
package bta_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int PAGE_W  = 11;
    localparam int LEN_W   = 2;
    localparam int SEL_W   = ADDR_W - PAGE_W;
    localparam int HI_W    = PAGE_W - BYTE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SEL_W-1:0]  page_t;

    typedef enum logic [1:0] {
        JM_REL   = 2'd0,
        JM_ABS   = 2'd1,
        JM_PCIDX = 2'd2,
        JM_DPIDX = 2'd3
    } jmode_e;

    typedef struct packed {
        addr_t target;
        logic  same_page;
    } tgt_res_t;

    function automatic addr_t sext_byte(input byte_t b);
        return {{(ADDR_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

    function automatic addr_t zext_byte(input byte_t b);
        return {{(ADDR_W-BYTE_W){1'b0}}, b};
    endfunction

    function automatic page_t page_of(input addr_t a);
        return a[ADDR_W-1:PAGE_W];
    endfunction

endpackage

// File: rtl/bta_seq_addr.sv
module bta_seq_addr
    import bta_pkg::*;
(
    input  addr_t            cur_addr,
    input  logic [LEN_W-1:0] len,
    output addr_t            next_addr
);
    always_comb begin
        next_addr = cur_addr + {{(ADDR_W-LEN_W){1'b0}}, len};
    end
endmodule

// File: rtl/bta_rel_path.sv
module bta_rel_path
    import bta_pkg::*;
(
    input  addr_t base,
    input  byte_t offset,
    output addr_t target
);
    always_comb begin
        target = base + sext_byte(offset);
    end
endmodule

// File: rtl/bta_abs_path.sv
module bta_abs_path
    import bta_pkg::*;
(
    input  addr_t base,
    input  byte_t opcode,
    input  byte_t lo_byte,
    output addr_t target
);
    logic [HI_W-1:0] hi_bits;

    always_comb begin
        hi_bits = opcode[BYTE_W-1 -: HI_W];
        target  = {page_of(base), hi_bits, lo_byte};
    end
endmodule

// File: rtl/bta_idx_path.sv
module bta_idx_path
    import bta_pkg::*;
(
    input  addr_t pc_base,
    input  addr_t ptr_base,
    input  logic  use_ptr,
    input  byte_t index,
    output addr_t target
);
    addr_t base_sel;

    always_comb begin
        base_sel = use_ptr ? ptr_base : pc_base;
        target   = base_sel + zext_byte(index);
    end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
    import bta_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] insn_addr_i,
    input  logic [LEN_W-1:0]  insn_len_i,
    input  logic [BYTE_W-1:0] opcode_i,
    input  logic [BYTE_W-1:0] operand_i,
    input  logic [BYTE_W-1:0] acc_i,
    input  logic [ADDR_W-1:0] dptr_i,
    output logic [ADDR_W-1:0] target_o,
    output logic              same_page_o
);
    addr_t    follow_addr;
    addr_t    rel_tgt;
    addr_t    abs_tgt;
    addr_t    idx_tgt;
    jmode_e   mode;
    tgt_res_t comb_res;
    tgt_res_t res_q;

    assign mode = jmode_e'(mode_i);

    bta_seq_addr u_seq (
        .cur_addr  (insn_addr_i),
        .len       (insn_len_i),
        .next_addr (follow_addr)
    );

    bta_rel_path u_rel (
        .base   (follow_addr),
        .offset (operand_i),
        .target (rel_tgt)
    );

    bta_abs_path u_abs (
        .base    (follow_addr),
        .opcode  (opcode_i),
        .lo_byte (operand_i),
        .target  (abs_tgt)
    );

    bta_idx_path u_idx (
        .pc_base  (follow_addr),
        .ptr_base (dptr_i),
        .use_ptr  (mode == JM_DPIDX),
        .index    (acc_i),
        .target   (idx_tgt)
    );

    always_comb begin
        unique case (mode)
            JM_REL:  comb_res.target = rel_tgt;
            JM_ABS:  comb_res.target = abs_tgt;
            default: comb_res.target = idx_tgt;
        endcase
        comb_res.same_page = (page_of(comb_res.target) == page_of(follow_addr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (valid_i) begin
            res_q <= comb_res;
        end
    end

    assign target_o    = res_q.target;
    assign same_page_o = res_q.same_page;

endmodule

// File: rtl/bta_chk.sv
module bta_chk
    import bta_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [1:0]        mode_i,
    input logic [ADDR_W-1:0] insn_addr_i,
    input logic [LEN_W-1:0]  insn_len_i,
    input logic [BYTE_W-1:0] opcode_i,
    input logic [BYTE_W-1:0] operand_i,
    input logic [BYTE_W-1:0] acc_i,
    input logic [ADDR_W-1:0] dptr_i,
    input logic [ADDR_W-1:0] target_o,
    input logic              same_page_o
);
    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(target_o) && $stable(same_page_o)));

    // R6
    abs_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i == 2'd1) |=>
        target_o[PAGE_W-1:0] == {$past(opcode_i[BYTE_W-1 -: HI_W]), $past(operand_i)});

    // R9
    abs_same_page_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i == 2'd1) |=> same_page_o);

    // R8
    ptr_index_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i == 2'd3) |=>
        target_o == ADDR_W'($past(dptr_i) + {{(ADDR_W-BYTE_W){1'b0}}, $past(acc_i)}));
endmodule

bind branch_target_unit bta_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .mode_i      (mode_i),
    .insn_addr_i (insn_addr_i),
    .insn_len_i  (insn_len_i),
    .opcode_i    (opcode_i),
    .operand_i   (operand_i),
    .acc_i       (acc_i),
    .dptr_i      (dptr_i),
    .target_o    (target_o),
    .same_page_o (same_page_o)
);

// File: tb/branch_target_unit_tb_top.sv
module branch_target_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [1:0]  mode_i;
    logic [15:0] insn_addr_i;
    logic [1:0]  insn_len_i;
    logic [7:0]  opcode_i;
    logic [7:0]  operand_i;
    logic [7:0]  acc_i;
    logic [15:0] dptr_i;
    logic [15:0] target_o;
    logic        same_page_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    branch_target_unit dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
        .insn_addr_i(insn_addr_i), .insn_len_i(insn_len_i),
        .opcode_i(opcode_i), .operand_i(operand_i), .acc_i(acc_i),
        .dptr_i(dptr_i), .target_o(target_o), .same_page_o(same_page_o)
    );

    task automatic check(input string req, input logic [15:0] got_t, input logic got_p,
                         input logic [15:0] exp_t, input logic exp_p);
        total++;
        if (got_t !== exp_t || got_p !== exp_p) begin
            bad++;
            $display("FAIL %s: target=%h same_page=%b expected target=%h same_page=%b",
                     req, got_t, got_p, exp_t, exp_p);
        end
    endtask

    function automatic logic same_pg(input logic [15:0] a, input logic [15:0] b);
        return a[15:11] == b[15:11];
    endfunction

    // Drive one request, strobe it, and sample after the capturing edge (R10).
    task automatic issue(input logic [1:0] m, input logic [15:0] a, input logic [1:0] l,
                         input logic [7:0] op, input logic [7:0] b2,
                         input logic [7:0] acc, input logic [15:0] dp);
        @(negedge clk);
        mode_i = m; insn_addr_i = a; insn_len_i = l; opcode_i = op;
        operand_i = b2; acc_i = acc; dptr_i = dp; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; valid_i = 1'b0; mode_i = 2'd0; insn_addr_i = 16'h1234;
        insn_len_i = 2'd2; opcode_i = 8'hFF; operand_i = 8'hFF; acc_i = 8'hFF; dptr_i = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R1 reset", target_o, same_page_o, 16'h0000, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_relative();
        // R5 worked example, R3 base after a 2-byte instruction
        issue(2'd0, 16'h1000, 2'd2, 8'h80, 8'h3E, 8'h00, 16'h0000);
        check("R5 rel fwd", target_o, same_page_o, 16'h1040, 1'b1);
        // R5 most negative offset, crosses page -> R9 flag 0
        issue(2'd0, 16'h1000, 2'd2, 8'h80, 8'h80, 8'h00, 16'h0000);
        check("R5 rel -128", target_o, same_page_o, 16'h0F82, same_pg(16'h0F82, 16'h1002));
        // R5 +127
        issue(2'd0, 16'h2000, 2'd3, 8'h00, 8'h7F, 8'h00, 16'h0000);
        check("R5 rel +127", target_o, same_page_o, 16'h2082, 1'b1);
        // R3 increment wraps, then add
        issue(2'd0, 16'hFFFE, 2'd2, 8'h00, 8'h05, 8'h00, 16'h0000);
        check("R3 rel wrap fwd", target_o, same_page_o, 16'h0005, 1'b1);
        // R5 wrap below zero
        issue(2'd0, 16'h0000, 2'd2, 8'h00, 8'hF0, 8'h00, 16'h0000);
        check("R5 rel wrap back", target_o, same_page_o, 16'hFFF2, 1'b0);
    endtask

    task automatic t_absolute();
        // R6 page bits come from follow-on address 0800h, not 07FEh
        issue(2'd1, 16'h07FE, 2'd2, 8'hE1, 8'h34, 8'h00, 16'h0000);
        check("R6 abs page carry", target_o, same_page_o, 16'h0F34, 1'b1);
        issue(2'd1, 16'h1234, 2'd2, 8'h21, 8'hAB, 8'h00, 16'h0000);
        check("R6 abs splice", target_o, same_page_o, 16'h11AB, 1'b1);
        // R4 mode 1 ignores acc and dptr
        issue(2'd1, 16'hF800, 2'd2, 8'h00, 8'h00, 8'hFF, 16'h1234);
        check("R4 abs mode", target_o, same_page_o, 16'hF800, 1'b1);
    endtask

    task automatic t_indexed();
        // R7 base is follow-on address
        issue(2'd2, 16'h2000, 2'd1, 8'h83, 8'h00, 8'hFF, 16'h5555);
        check("R7 pc idx", target_o, same_page_o, 16'h2100, 1'b1);
        issue(2'd2, 16'hFFFF, 2'd1, 8'h83, 8'h00, 8'h10, 16'h5555);
        check("R7 pc idx wrap", target_o, same_page_o, 16'h0010, 1'b1);
        // R8 pointer base; R9 page differs from follow-on 0101h
        issue(2'd3, 16'h0100, 2'd1, 8'h73, 8'h00, 8'h7F, 16'h8000);
        check("R8 ptr idx", target_o, same_page_o, 16'h807F, 1'b0);
        // R8 acc is unsigned (80h adds +128)
        issue(2'd3, 16'h0100, 2'd1, 8'h73, 8'h00, 8'h80, 16'h1000);
        check("R8 ptr unsigned", target_o, same_page_o, 16'h1080, 1'b0);
        issue(2'd3, 16'h0000, 2'd1, 8'h73, 8'h00, 8'h20, 16'hFFF0);
        check("R8 ptr wrap", target_o, same_page_o, 16'h0010, 1'b1);
    endtask

    task automatic t_hold();
        issue(2'd0, 16'h1000, 2'd2, 8'h80, 8'h3E, 8'h00, 16'h0000);
        @(negedge clk);
        mode_i = 2'd3; dptr_i = 16'hABCD; acc_i = 8'h11; insn_addr_i = 16'h7777;
        repeat (3) @(negedge clk);
        check("R2 hold idle", target_o, same_page_o, 16'h1040, 1'b1);
    endtask

    initial begin
        t_reset();
        t_relative();
        t_absolute();
        t_indexed();
        t_hold();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule